// File: doc/BRIEF.md
# Cache Way Lock Controller

This block picks the way that a four-way set-associative cache fills on a miss. It also lets software pin single lines so that normal replacement never evicts them. The block serves three caches: the primary instruction cache, the primary data cache and the secondary cache. Each cache has its own lock bits and its own replacement pointer. One control word arms locking. It holds an enable bit for each cache and a single way-select bit that the three caches share. While a cache's enable is set, every fill of the right kind into that cache goes to the selected way and pins the line there. Software arms the mode, touches the lines it wants to keep, and then disarms the mode.

Only the first two ways, A (way 0) and B (way 1), can hold a pinned line. Fills that do not lock use round-robin replacement and skip pinned ways. If no way is free, the fill bypasses the cache. A per-line unlock command releases a single pin. A status port reports the pin pattern of any set. The block has no tag store, no data store and no miss or bus handling.

Top module: `way_lock_ctrl`

## Requirements
- R1: Reset clears every lock bit, the control word and every replacement pointer to zero. After reset, every status query returns 0 and the first normal fill in each cache chooses way 0.
- R2: A control write on `cfg_we` decodes four bits of `cfg_wdata`: bit 27 enables locking for the instruction cache, bit 26 for the data cache, bit 25 for the secondary cache, and bit 28 selects the target way (0 = way 0, 1 = way 1). All other bits are ignored. A fill in the same cycle as a write uses the old setting, and the new setting applies from the next cycle.
- R3: Cache ids are 0 = instruction, 1 = data, 2 = secondary. Fill kinds are 0 = fetch, 1 = cache-op fill, 2 = load, 3 = store. An instruction-cache fill of kind 1 with its enable set is a locking fill. It drives `fill_way` to the selected way and raises `fill_lock`, and that line's lock bit is set at the next edge.
- R4: A data-cache fill of kind 2 or 3 with the data enable set is a locking fill, with the same outputs and effect as in R3.
- R5: A secondary-cache fill of kind 1, 2 or 3 with the secondary enable set is a locking fill, with the same outputs and effect as in R3.
- R6: Any other fill, whether the kind does not qualify or the enable is clear, uses normal replacement with `fill_lock` low. Such a fill never changes any lock bit.
- R7: Normal replacement chooses the first unlocked way, searching upward from the cache's pointer and wrapping. After an allocating normal fill the pointer moves to the chosen way plus one, modulo the way count. Locking fills do not move the pointer, and each cache has its own pointer.
- R8: If every way of the addressed set is locked, a normal fill raises `fill_no_alloc`, changes no state and leaves the pointer where it was. A locking fill always allocates.
- R9: An unlock command clears only the named lock bit. An unlock that names a way of 2 or higher, or a line that is not locked, changes nothing. If a locking fill and an unlock hit the same lock bit in the same cycle, the lock bit ends set.
- R10: `stat_mask` combinationally shows the lock bits of set `stat_index` in cache `stat_cache`, with bit w standing for way w. Bits for ways 2 and higher are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| fill_valid | input | 1 | A fill request is present this cycle |
| fill_cache | input | 2 | Cache id of the fill |
| fill_index | input | IDX_W | Set index of the fill |
| fill_kind | input | 2 | Kind of access causing the fill |
| unlock_valid | input | 1 | Unlock command strobe |
| unlock_cache | input | 2 | Cache id of the unlock |
| unlock_index | input | IDX_W | Set index of the unlock |
| unlock_way | input | WAY_W | Way whose lock bit is cleared |
| stat_cache | input | 2 | Cache id for the status query |
| stat_index | input | IDX_W | Set index for the status query |
| fill_way | output | WAY_W | Way chosen for the current fill |
| fill_lock | output | 1 | The current fill pins its line |
| fill_no_alloc | output | 1 | All ways locked; the fill bypasses the cache |
| stat_mask | output | NUM_WAYS | Lock bits of the queried set |

## Verification
A lock bit that is set or cleared wrongly appears on `stat_mask` in the cycle after the fill or unlock that caused it. It also changes the way that the next normal fill into that set reports, in the same cycle that fill is presented. A replacement pointer that is off shows up in `fill_way` of the very next normal fill into that cache. A wrong control decode shows up on `fill_lock` of the first fill after the write. No fault can stay hidden for more than one fill and one query.

// File: rtl/wlk_pkg.sv
`timescale 1ns/1ps
package wlk_pkg;

  localparam int NCACHE   = 3;
  localparam int LOCKABLE = 2;

  localparam int CFG_EN_INSN_BIT = 27;
  localparam int CFG_EN_DATA_BIT = 26;
  localparam int CFG_EN_L2_BIT   = 25;
  localparam int CFG_SEL_BIT     = 28;

  typedef enum logic [1:0] {
    CID_INSN = 2'd0,
    CID_DATA = 2'd1,
    CID_L2   = 2'd2,
    CID_NONE = 2'd3
  } cache_id_e;

  typedef enum logic [1:0] {
    FK_FETCH   = 2'd0,
    FK_CACHEOP = 2'd1,
    FK_LOAD    = 2'd2,
    FK_STORE   = 2'd3
  } fill_kind_e;

  typedef struct packed {
    logic              sel;
    logic [NCACHE-1:0] en;   // [0] insn, [1] data, [2] secondary
  } lock_cfg_t;

  function automatic lock_cfg_t decode_cfg(input logic [31:0] w);
    lock_cfg_t r;
    r.sel            = w[CFG_SEL_BIT];
    r.en[CID_INSN]   = w[CFG_EN_INSN_BIT];
    r.en[CID_DATA]   = w[CFG_EN_DATA_BIT];
    r.en[CID_L2]     = w[CFG_EN_L2_BIT];
    return r;
  endfunction

  // Which fill kinds pin a line in a given cache while its enable is set
  function automatic logic kind_arms_lock(input cache_id_e c, input fill_kind_e k);
    case (c)
      CID_INSN: return k == FK_CACHEOP;
      CID_DATA: return (k == FK_LOAD) || (k == FK_STORE);
      CID_L2:   return k != FK_FETCH;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/wlk_cfg_reg.sv
`timescale 1ns/1ps
module wlk_cfg_reg
  import wlk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output lock_cfg_t   cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n)   cfg <= '0;
    else if (we)  cfg <= decode_cfg(wdata);
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg)); // R2

endmodule

// File: rtl/wlk_lock_array.sv
`timescale 1ns/1ps
module wlk_lock_array
  import wlk_pkg::*;
#(
  parameter int NUM_SETS = 64,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                set_way,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  input  logic                clr_way,
  input  logic [IDX_W-1:0]    rd_a_idx,
  output logic [LOCKABLE-1:0] rd_a,
  input  logic [IDX_W-1:0]    rd_b_idx,
  output logic [LOCKABLE-1:0] rd_b
);

  logic [LOCKABLE-1:0] bits_q [NUM_SETS];

  function automatic logic in_range(input logic [IDX_W-1:0] i);
    return int'(i) < NUM_SETS;
  endfunction

  // Clear is applied first so that a same-line set wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) bits_q[s] <= '0;
    end else begin
      if (clr_en && in_range(clr_idx)) bits_q[clr_idx][clr_way] <= 1'b0;
      if (set_en && in_range(set_idx)) bits_q[set_idx][set_way] <= 1'b1;
    end
  end

  always_comb begin
    rd_a = in_range(rd_a_idx) ? bits_q[rd_a_idx] : '0;
    rd_b = in_range(rd_b_idx) ? bits_q[rd_b_idx] : '0;
  end

  logic same_line;
  assign same_line = set_en && clr_en && (set_idx == clr_idx) && (set_way == clr_way);

  AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> bits_q[$past(set_idx)][$past(set_way)]); // R3
  AST_UNLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !same_line) |=> !bits_q[$past(clr_idx)][$past(clr_way)]); // R9

endmodule

// File: rtl/wlk_victim_sel.sv
`timescale 1ns/1ps
module wlk_victim_sel #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAYS-1:0] locked,
  input  logic                alloc_en,
  output logic [WAY_W-1:0]    victim,
  output logic                all_locked
);

  logic [WAY_W-1:0] ptr_q;

  function automatic logic [WAY_W-1:0] wrap_add(input logic [WAY_W-1:0] p, input int k);
    return WAY_W'((int'(p) + k) % NUM_WAYS);
  endfunction

  always_comb begin
    logic found;
    logic [WAY_W-1:0] cand;
    found  = 1'b0;
    victim = ptr_q;
    for (int k = 0; k < NUM_WAYS; k++) begin
      cand = wrap_add(ptr_q, k);
      if (!found && !locked[cand]) begin
        victim = cand;
        found  = 1'b1;
      end
    end
    all_locked = !found;
  end

  logic adv_evt;
  assign adv_evt = alloc_en && !all_locked;

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr_q <= '0;
    else if (adv_evt)  ptr_q <= wrap_add(victim, 1);
  end

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |-> !locked[victim]); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_evt |=> $stable(ptr_q)); // R7
  AST_FULL_MEANS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    all_locked |-> (&locked)); // R8

endmodule

// File: rtl/way_lock_ctrl.sv
`timescale 1ns/1ps
module way_lock_ctrl
  import wlk_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 4,
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [31:0]         cfg_wdata,
  input  logic                fill_valid,
  input  logic [1:0]          fill_cache,
  input  logic [IDX_W-1:0]    fill_index,
  input  logic [1:0]          fill_kind,
  input  logic                unlock_valid,
  input  logic [1:0]          unlock_cache,
  input  logic [IDX_W-1:0]    unlock_index,
  input  logic [WAY_W-1:0]    unlock_way,
  input  logic [1:0]          stat_cache,
  input  logic [IDX_W-1:0]    stat_index,
  output logic [WAY_W-1:0]    fill_way,
  output logic                fill_lock,
  output logic                fill_no_alloc,
  output logic [NUM_WAYS-1:0] stat_mask
);

  lock_cfg_t cfg;

  wlk_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  logic [NCACHE-1:0]   lock_evt;
  logic [NCACHE-1:0]   full_v;
  logic [WAY_W-1:0]    vic     [NCACHE];
  logic [NUM_WAYS-1:0] stat_m  [NCACHE];

  logic unlock_ok;
  assign unlock_ok = unlock_valid && (int'(unlock_way) < LOCKABLE);

  for (genvar c = 0; c < NCACHE; c++) begin : g_cache
    localparam cache_id_e CID = cache_id_e'(c);

    logic                fill_hit;
    logic                alloc_en;
    logic                clr_en;
    logic [LOCKABLE-1:0] lk_fill;
    logic [LOCKABLE-1:0] lk_stat;
    logic [NUM_WAYS-1:0] mask_fill;

    assign fill_hit    = fill_valid && (fill_cache == CID);
    assign lock_evt[c] = fill_hit && cfg.en[c] && kind_arms_lock(CID, fill_kind_e'(fill_kind));
    assign alloc_en    = fill_hit && !lock_evt[c];
    assign clr_en      = unlock_ok && (unlock_cache == CID);

    wlk_lock_array #(.NUM_SETS(NUM_SETS)) u_lk (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (lock_evt[c]),
      .set_idx  (fill_index),
      .set_way  (cfg.sel),
      .clr_en   (clr_en),
      .clr_idx  (unlock_index),
      .clr_way  (unlock_way[0]),
      .rd_a_idx (fill_index),
      .rd_a     (lk_fill),
      .rd_b_idx (stat_index),
      .rd_b     (lk_stat)
    );

    always_comb begin
      mask_fill = '0;
      mask_fill[LOCKABLE-1:0] = lk_fill;
      stat_m[c] = '0;
      stat_m[c][LOCKABLE-1:0] = lk_stat;
    end

    wlk_victim_sel #(.NUM_WAYS(NUM_WAYS)) u_vs (
      .clk        (clk),
      .rst_n      (rst_n),
      .locked     (mask_fill),
      .alloc_en   (alloc_en),
      .victim     (vic[c]),
      .all_locked (full_v[c])
    );
  end

  // Named events for the checks below
  logic evt_lock_fill;
  logic evt_bypass;
  assign evt_lock_fill = |lock_evt;

  always_comb begin
    fill_way      = '0;
    fill_lock     = 1'b0;
    fill_no_alloc = 1'b0;
    stat_mask     = '0;
    for (int c = 0; c < NCACHE; c++) begin
      if (fill_valid && fill_cache == 2'(c)) begin
        if (lock_evt[c]) begin
          fill_way  = WAY_W'(cfg.sel);
          fill_lock = 1'b1;
        end else begin
          fill_way      = vic[c];
          fill_no_alloc = full_v[c];
        end
      end
      if (stat_cache == 2'(c)) stat_mask = stat_m[c];
    end
  end

  assign evt_bypass = fill_no_alloc;

  AST_LOCK_TARGET_AB: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lock |-> (int'(fill_way) < LOCKABLE)); // R3
  AST_LOCK_ALLOCATES: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lock_fill |-> !evt_bypass); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid |-> (!fill_lock && !fill_no_alloc)); // R6
  AST_ONE_LOCKER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_evt)); // R3
  AST_HIGH_WAYS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_mask >> LOCKABLE) == '0); // R10

endmodule

// File: tb/test_way_lock_ctrl.sv
`timescale 1ns/1ps
module test_way_lock_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        fill_valid = 1'b0;
  logic [1:0]  fill_cache = '0;
  logic [5:0]  fill_index = '0;
  logic [1:0]  fill_kind = '0;
  logic        unlock_valid = 1'b0;
  logic [1:0]  unlock_cache = '0;
  logic [5:0]  unlock_index = '0;
  logic [1:0]  unlock_way = '0;
  logic [1:0]  stat_cache = '0;
  logic [5:0]  stat_index = '0;

  logic [1:0]  fill_way;
  logic        fill_lock, fill_no_alloc;
  logic [3:0]  stat_mask;
  logic        w2_way, w2_lock, w2_na;
  logic [1:0]  w2_mask;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  way_lock_ctrl #(.NUM_SETS(64), .NUM_WAYS(4)) i_way_lock_ctrl (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .fill_valid, .fill_cache, .fill_index,
    .fill_kind, .unlock_valid, .unlock_cache, .unlock_index, .unlock_way,
    .stat_cache, .stat_index, .fill_way, .fill_lock, .fill_no_alloc, .stat_mask
  );

  way_lock_ctrl #(.NUM_SETS(64), .NUM_WAYS(2)) i_way_lock_ctrl_w2 (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .fill_valid, .fill_cache, .fill_index,
    .fill_kind, .unlock_valid, .unlock_cache, .unlock_index,
    .unlock_way (unlock_way[0:0]),
    .stat_cache, .stat_index,
    .fill_way (w2_way), .fill_lock (w2_lock), .fill_no_alloc (w2_na),
    .stat_mask (w2_mask)
  );

  localparam logic [31:0] EN_I = 32'h0800_0000;
  localparam logic [31:0] EN_D = 32'h0400_0000;
  localparam logic [31:0] EN_S = 32'h0200_0000;
  localparam logic [31:0] SELB = 32'h1000_0000;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_cfg(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic do_fill(input logic [1:0] c, input logic [5:0] idx, input logic [1:0] k,
                         input int ew, input int elk, input int ena, input string req,
                         input bit chk_w2 = 0, input int w2w = 0, input int w2na = 0);
    @(negedge clk);
    fill_valid = 1'b1; fill_cache = c; fill_index = idx; fill_kind = k;
    #1;
    chk(req, "fill_way", fill_way, ew);
    chk(req, "fill_lock", fill_lock, elk);
    chk(req, "fill_no_alloc", fill_no_alloc, ena);
    if (chk_w2) begin
      chk(req, "w2 fill_no_alloc", w2_na, w2na);
      if (w2na == 0) chk(req, "w2 fill_way", w2_way, w2w);
    end
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic do_unlock(input logic [1:0] c, input logic [5:0] idx, input logic [1:0] w);
    @(negedge clk);
    unlock_valid = 1'b1; unlock_cache = c; unlock_index = idx; unlock_way = w;
    @(posedge clk); #1;
    unlock_valid = 1'b0;
  endtask

  task automatic query(input logic [1:0] c, input logic [5:0] idx, input int em, input string req);
    @(negedge clk);
    stat_cache = c; stat_index = idx;
    #1;
    chk(req, "stat_mask", stat_mask, em);
  endtask

  task automatic t_reset();
    do_reset();
    query(0, 0, 0, "R1");
    query(2, 5, 0, "R1");
    wr_cfg(EN_I);
    do_fill(0, 8, 1, 0, 1, 0, "R3");
    do_reset();
    query(0, 8, 0, "R1");
    do_fill(0, 8, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_round_robin();
    do_reset();
    do_fill(1, 1, 2, 0, 0, 0, "R7");
    do_fill(1, 2, 2, 1, 0, 0, "R7");
    do_fill(1, 1, 2, 2, 0, 0, "R7");
    do_fill(1, 9, 3, 3, 0, 0, "R7");
    do_fill(1, 1, 2, 0, 0, 0, "R7");
    do_fill(0, 1, 0, 0, 0, 0, "R7");
  endtask

  task automatic t_insn_lock();
    do_reset();
    wr_cfg(EN_I);
    do_fill(0, 4, 1, 0, 1, 0, "R3");
    query(0, 4, 4'b0001, "R3");
    do_fill(0, 4, 0, 1, 0, 0, "R6");
    do_fill(0, 4, 0, 2, 0, 0, "R7");
    wr_cfg(EN_I | SELB);
    do_fill(0, 4, 1, 1, 1, 0, "R3");
    query(0, 4, 4'b0011, "R10");
    query(1, 4, 0, "R10");
    wr_cfg(0);
    do_fill(0, 4, 0, 3, 0, 0, "R7");
    do_fill(0, 4, 0, 2, 0, 0, "R7");
    do_fill(0, 4, 0, 3, 0, 0, "R7");
  endtask

  task automatic t_data_lock();
    do_reset();
    wr_cfg(EN_D | SELB);
    do_fill(1, 7, 3, 1, 1, 0, "R4");
    do_fill(1, 7, 1, 0, 0, 0, "R6");
    do_fill(1, 7, 2, 1, 1, 0, "R4");
    do_fill(0, 7, 1, 0, 0, 0, "R6");
    query(1, 7, 4'b0010, "R4");
    query(0, 7, 0, "R6");
  endtask

  task automatic t_l2_lock();
    do_reset();
    wr_cfg(EN_S);
    do_fill(2, 2, 2, 0, 1, 0, "R5");
    do_fill(2, 2, 0, 1, 0, 0, "R6");
    do_fill(2, 9, 1, 0, 1, 0, "R5");
    query(2, 2, 4'b0001, "R5");
    query(2, 9, 4'b0001, "R5");
  endtask

  task automatic t_unlock();
    do_reset();
    wr_cfg(EN_I);
    do_fill(0, 10, 1, 0, 1, 0, "R3");
    wr_cfg(EN_I | SELB);
    do_fill(0, 10, 1, 1, 1, 0, "R3");
    query(0, 10, 4'b0011, "R9");
    do_unlock(0, 10, 0);
    query(0, 10, 4'b0010, "R9");
    do_unlock(0, 11, 1);
    query(0, 10, 4'b0010, "R9");
    do_unlock(0, 10, 2);
    query(0, 10, 4'b0010, "R9");
    do_unlock(1, 10, 1);
    query(0, 10, 4'b0010, "R9");
    wr_cfg(0);
    do_fill(0, 10, 0, 0, 0, 0, "R9");
  endtask

  task automatic t_collision();
    do_reset();
    wr_cfg(EN_I);
    @(negedge clk);
    fill_valid = 1'b1; fill_cache = 0; fill_index = 12; fill_kind = 1;
    unlock_valid = 1'b1; unlock_cache = 0; unlock_index = 12; unlock_way = 0;
    #1;
    chk("R9", "fill_lock", fill_lock, 1);
    @(posedge clk); #1;
    fill_valid = 1'b0; unlock_valid = 1'b0;
    query(0, 12, 4'b0001, "R9");
  endtask

  task automatic t_cfg_decode();
    do_reset();
    wr_cfg(32'hE1FF_FFFF);
    do_fill(2, 3, 2, 0, 0, 0, "R2");
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = EN_S;
    fill_valid = 1'b1; fill_cache = 2; fill_index = 3; fill_kind = 2;
    #1;
    chk("R2", "fill_lock same-cycle", fill_lock, 0);
    chk("R2", "fill_way same-cycle", fill_way, 1);
    @(posedge clk); #1;
    cfg_we = 1'b0; fill_valid = 1'b0;
    do_fill(2, 3, 2, 0, 1, 0, "R2");
    query(2, 3, 4'b0001, "R2");
  endtask

  task automatic t_no_alloc();
    do_reset();
    wr_cfg(EN_S);
    do_fill(2, 0, 2, 0, 1, 0, "R8", 1, 0, 0);
    wr_cfg(EN_S | SELB);
    do_fill(2, 0, 2, 1, 1, 0, "R8", 1, 1, 0);
    wr_cfg(0);
    do_fill(2, 0, 2, 2, 0, 0, "R8", 1, 0, 1);
    do_unlock(2, 0, 1);
    do_fill(2, 0, 2, 3, 0, 0, "R8", 1, 1, 0);
    do_fill(2, 1, 2, 0, 0, 0, "R7", 1, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_round_robin();
    t_insn_lock();
    t_data_lock();
    t_l2_lock();
    t_unlock();
    t_collision();
    t_cfg_decode();
    t_no_alloc();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule